// File: doc/BRIEF.md
# Paged Register Bus Slave

This block is the register front end of an acquisition card on a shared byte-wide control bus with a 13-bit address. It recognises two kinds of access. One is an individual access whose high address nibble matches the card's board switch. The other is a broadcast window that every card on the bus answers at once. The page registers sit behind that decode. They choose which page of the threshold, settings and sum memories the card uses and which page the bus can see. The block also holds the map-select flag that the address translator downstream uses.

Sum pages advance by themselves. The fast, slow and very-slow latch strobes each copy the sum page in use into their own readout page register, and each strobe advances the page in use by one, wrapping at eight. Software can set a freeze bit in a readout page register, and latch strobes then leave that register alone while it reads the sums. A read inside the broadcast window returns the card's own data and raises a flag, so the collision can be seen.

Top module: `pg_bus_slave`

## Requirements
- R1: The card is selected when addr[12] is 0, addr[11:8] equals board_id_i, and board_id_i is not 0xF. Any other address outside the broadcast window leaves every register unchanged, returns rdata 0, and holds bus_sel_o low.
- R2: When addr[12:8] is 0x13, the card is selected for every board id. A write there updates the byte at offset addr[7:0].
- R3: A read inside the broadcast window returns the card's own register byte and sets bcast_rd_o high in the same cycle. An individual read leaves bcast_rd_o low.
- R4: Offset 0xE0 holds the threshold page in use and 0xE1 the threshold page the bus sees. Their low 6 bits drive thr_use_pg_o and thr_bus_pg_o.
- R5: The low 3 bits of five registers drive page outputs: 0xE2 drives set_use_pg_o, 0xE3 drives set_bus_pg_o, 0xE4 drives sum_use_pg_o, and 0xE5, 0xE6 and 0xE7 drive the fast, slow and very-slow readout pages (sum_f_pg_o, sum_s_pg_o, sum_v_pg_o).
- R6: latch_i[0], [1] and [2] are the fast, slow and very-slow strobes. When a strobe is high at an edge, the low 3 bits of its readout page take the old in-use sum page, and the in-use page advances by 1 modulo 8. Both changes are visible after that edge.
- R7: While bit 7 of a readout page register is set, latch strobes leave that register unchanged. The in-use page still advances.
- R8: When several strobes are high in the same cycle, they all load the same pre-advance value, and the in-use page advances by exactly 1.
- R9: Bit 7 of offset 0xFF drives native_map_o, where 1 selects the native map. Its reset value is 0.
- R10: After reset, every page register and the 0xFF register read 0x00, and every page output is 0.
- R11: Page registers read back all 8 bits written to them. Offsets outside 0xE0 to 0xE7 and 0xFF ignore writes and read 0x00.
- R12: A bus write to a page register takes priority over a latch strobe for that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| board_id_i | input | 4 | Board switch setting |
| addr_i | input | 13 | Bus address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| bus_sel_o | output | 1 | Card selected (individual or broadcast) |
| bcast_rd_o | output | 1 | Read seen in the broadcast window |
| latch_i | input | 3 | Fast, slow and very-slow sum latch strobes |
| thr_use_pg_o | output | 6 | Threshold page in use |
| thr_bus_pg_o | output | 6 | Threshold page seen by the bus |
| set_use_pg_o | output | 3 | Settings page in use |
| set_bus_pg_o | output | 3 | Settings page seen by the bus |
| sum_use_pg_o | output | 3 | Sum page in use |
| sum_f_pg_o | output | 3 | Fast sum readout page |
| sum_s_pg_o | output | 3 | Slow sum readout page |
| sum_v_pg_o | output | 3 | Very-slow sum readout page |
| native_map_o | output | 1 | Native map selected |

## Verification
The hardest case to reach is a latch cycle that mixes several conditions. In that cycle one readout register is frozen, others are live, and the in-use page sits at its wrap value. A second hard case is a bus write to one readout page that lands in the same cycle as its own strobe. The stimulus first loads the in-use page and a frozen readout page with chosen values. It then pulses all three strobes together, and it issues a write and a strobe in one cycle. Reading the registers back afterwards shows the shared pre-advance value, the single advance and the write's priority.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  localparam int OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_THR_USE = 8'hE0;
  localparam logic [OFF_W-1:0] OFF_THR_BUS = 8'hE1;
  localparam logic [OFF_W-1:0] OFF_SET_USE = 8'hE2;
  localparam logic [OFF_W-1:0] OFF_SET_BUS = 8'hE3;
  localparam logic [OFF_W-1:0] OFF_SUM_USE = 8'hE4;
  localparam logic [OFF_W-1:0] OFF_SUM_RO0 = 8'hE5;  // fast, slow, very-slow follow in order
  localparam logic [OFF_W-1:0] OFF_MAP     = 8'hFF;

  typedef enum logic [1:0] {
    LT_FAST  = 2'd0,
    LT_SLOW  = 2'd1,
    LT_VSLOW = 2'd2
  } latch_kind_e;
endpackage

// File: rtl/pgb_addr_dec.sv
module pgb_addr_dec #(
  parameter int ADDR_W = 13,
  parameter int OFF_W = 8,
  parameter logic [ADDR_W-OFF_W-1:0] BCAST_TAG = 5'h13
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-OFF_W-2:0] board_id_i,
  output logic                    ind_sel_o,
  output logic                    bc_sel_o,
  output logic [OFF_W-1:0]        off_o
);
  localparam int ID_W = ADDR_W - OFF_W - 1;

  logic id_valid;
  assign id_valid  = (board_id_i != {ID_W{1'b1}});
  assign ind_sel_o = !addr_i[ADDR_W-1] && id_valid &&
                     (addr_i[ADDR_W-2:OFF_W] == board_id_i);
  assign bc_sel_o  = (addr_i[ADDR_W-1:OFF_W] == BCAST_TAG);
  assign off_o     = addr_i[OFF_W-1:0];
endmodule

// File: rtl/pgb_page_bank.sv
module pgb_page_bank
  import pgb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUM_PG_W = 3,
  parameter int N_LATCH = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [OFF_W-1:0]               off_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [N_LATCH-1:0]             latch_i,
  output logic [DATA_W-1:0]              thr_use_q_o,
  output logic [DATA_W-1:0]              thr_bus_q_o,
  output logic [DATA_W-1:0]              set_use_q_o,
  output logic [DATA_W-1:0]              set_bus_q_o,
  output logic [DATA_W-1:0]              sum_u_q_o,
  output logic [N_LATCH-1:0][DATA_W-1:0] ro_q_o,
  output logic [DATA_W-1:0]              map_q_o
);
  localparam int FRZ_BIT = DATA_W - 1;
  localparam logic [SUM_PG_W-1:0] PG_ONE = {{(SUM_PG_W-1){1'b0}}, 1'b1};

  function automatic logic hit(input logic en, input logic [OFF_W-1:0] a,
                               input logic [OFF_W-1:0] b);
    return en && (a == b);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_use_q_o <= '0;
      thr_bus_q_o <= '0;
      set_use_q_o <= '0;
      set_bus_q_o <= '0;
      map_q_o     <= '0;
    end else begin
      if (hit(wr_en_i, off_i, OFF_THR_USE)) thr_use_q_o <= wdata_i;
      if (hit(wr_en_i, off_i, OFF_THR_BUS)) thr_bus_q_o <= wdata_i;
      if (hit(wr_en_i, off_i, OFF_SET_USE)) set_use_q_o <= wdata_i;
      if (hit(wr_en_i, off_i, OFF_SET_BUS)) set_bus_q_o <= wdata_i;
      if (hit(wr_en_i, off_i, OFF_MAP))     map_q_o     <= wdata_i;
    end
  end

  // in-use sum page: one advance per latch cycle, however many strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_u_q_o <= '0;
    end else if (hit(wr_en_i, off_i, OFF_SUM_USE)) begin
      sum_u_q_o <= wdata_i;
    end else if (|latch_i) begin
      sum_u_q_o[SUM_PG_W-1:0] <= sum_u_q_o[SUM_PG_W-1:0] + PG_ONE;
    end
  end

  for (genvar k = 0; k < N_LATCH; k++) begin : g_ro
    localparam logic [OFF_W-1:0] MY_OFF = OFF_SUM_RO0 + OFF_W'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ro_q_o[k] <= '0;
      end else if (hit(wr_en_i, off_i, MY_OFF)) begin
        ro_q_o[k] <= wdata_i;
      end else if (latch_i[k] && !ro_q_o[k][FRZ_BIT]) begin
        ro_q_o[k][SUM_PG_W-1:0] <= sum_u_q_o[SUM_PG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pgb_rd_mux.sv
module pgb_rd_mux
  import pgb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_LATCH = 3
) (
  input  logic [OFF_W-1:0]               off_i,
  input  logic [DATA_W-1:0]              thr_use_q_i,
  input  logic [DATA_W-1:0]              thr_bus_q_i,
  input  logic [DATA_W-1:0]              set_use_q_i,
  input  logic [DATA_W-1:0]              set_bus_q_i,
  input  logic [DATA_W-1:0]              sum_u_q_i,
  input  logic [N_LATCH-1:0][DATA_W-1:0] ro_q_i,
  input  logic [DATA_W-1:0]              map_q_i,
  output logic [DATA_W-1:0]              data_o
);
  always_comb begin
    data_o = '0;
    unique case (off_i)
      OFF_THR_USE: data_o = thr_use_q_i;
      OFF_THR_BUS: data_o = thr_bus_q_i;
      OFF_SET_USE: data_o = set_use_q_i;
      OFF_SET_BUS: data_o = set_bus_q_i;
      OFF_SUM_USE: data_o = sum_u_q_i;
      OFF_MAP:     data_o = map_q_i;
      default: begin
        for (int k = 0; k < N_LATCH; k++)
          if (off_i == OFF_SUM_RO0 + OFF_W'(k)) data_o = ro_q_i[k];
      end
    endcase
  end
endmodule

// File: rtl/pg_bus_slave.sv
module pg_bus_slave
  import pgb_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int THR_PG_W = 6,
  parameter int SET_PG_W = 3,
  parameter int SUM_PG_W = 3,
  parameter int N_LATCH = 3,
  parameter logic [ADDR_W-OFF_W-1:0] BCAST_TAG = 5'h13,
  localparam int ID_W = ADDR_W - OFF_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ID_W-1:0]     board_id_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                bus_sel_o,
  output logic                bcast_rd_o,
  input  logic [N_LATCH-1:0]  latch_i,
  output logic [THR_PG_W-1:0] thr_use_pg_o,
  output logic [THR_PG_W-1:0] thr_bus_pg_o,
  output logic [SET_PG_W-1:0] set_use_pg_o,
  output logic [SET_PG_W-1:0] set_bus_pg_o,
  output logic [SUM_PG_W-1:0] sum_use_pg_o,
  output logic [SUM_PG_W-1:0] sum_f_pg_o,
  output logic [SUM_PG_W-1:0] sum_s_pg_o,
  output logic [SUM_PG_W-1:0] sum_v_pg_o,
  output logic                native_map_o
);
  logic                           ind_sel, bc_sel, sel, wr_en;
  logic [OFF_W-1:0]               off;
  logic [DATA_W-1:0]              thr_use_q, thr_bus_q, set_use_q, set_bus_q, sum_u_q, map_q;
  logic [N_LATCH-1:0][DATA_W-1:0] ro_q;
  logic [DATA_W-1:0]              mux_data;

  pgb_addr_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BCAST_TAG(BCAST_TAG)) i_dec (
    .addr_i(addr_i), .board_id_i(board_id_i),
    .ind_sel_o(ind_sel), .bc_sel_o(bc_sel), .off_o(off)
  );

  assign sel   = ind_sel | bc_sel;
  assign wr_en = wr_i & sel;

  pgb_page_bank #(.DATA_W(DATA_W), .SUM_PG_W(SUM_PG_W), .N_LATCH(N_LATCH)) i_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .off_i(off), .wdata_i(wdata_i),
    .latch_i(latch_i),
    .thr_use_q_o(thr_use_q), .thr_bus_q_o(thr_bus_q),
    .set_use_q_o(set_use_q), .set_bus_q_o(set_bus_q),
    .sum_u_q_o(sum_u_q), .ro_q_o(ro_q), .map_q_o(map_q)
  );

  pgb_rd_mux #(.DATA_W(DATA_W), .N_LATCH(N_LATCH)) i_mux (
    .off_i(off), .thr_use_q_i(thr_use_q), .thr_bus_q_i(thr_bus_q),
    .set_use_q_i(set_use_q), .set_bus_q_i(set_bus_q), .sum_u_q_i(sum_u_q),
    .ro_q_i(ro_q), .map_q_i(map_q), .data_o(mux_data)
  );

  assign rdata_o      = (rd_i && sel) ? mux_data : '0;
  assign bus_sel_o    = sel;
  assign bcast_rd_o   = rd_i && bc_sel;
  assign thr_use_pg_o = thr_use_q[THR_PG_W-1:0];
  assign thr_bus_pg_o = thr_bus_q[THR_PG_W-1:0];
  assign set_use_pg_o = set_use_q[SET_PG_W-1:0];
  assign set_bus_pg_o = set_bus_q[SET_PG_W-1:0];
  assign sum_use_pg_o = sum_u_q[SUM_PG_W-1:0];
  assign sum_f_pg_o   = ro_q[LT_FAST][SUM_PG_W-1:0];
  assign sum_s_pg_o   = ro_q[LT_SLOW][SUM_PG_W-1:0];
  assign sum_v_pg_o   = ro_q[LT_VSLOW][SUM_PG_W-1:0];
  assign native_map_o = map_q[DATA_W-1];
endmodule

// File: rtl/pg_bus_slave_chk.sv
module pg_bus_slave_chk
  import pgb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUM_PG_W = 3,
  parameter int N_LATCH = 3
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           rd_i,
  input logic                           bcast_rd_o,
  input logic                           ind_sel,
  input logic                           bc_sel,
  input logic                           wr_en,
  input logic [OFF_W-1:0]               off,
  input logic [N_LATCH-1:0]             latch_i,
  input logic [DATA_W-1:0]              sum_u_q,
  input logic [N_LATCH-1:0][DATA_W-1:0] ro_q,
  input logic                           native_map_o
);
  logic wr_u, wr_map;
  assign wr_u   = wr_en && (off == OFF_SUM_USE);
  assign wr_map = wr_en && (off == OFF_MAP);

  // R1
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ind_sel, bc_sel}));

  // R3
  bcast_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_rd_o |-> (rd_i && bc_sel));

  // R8
  u_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|latch_i && !wr_u) |=> sum_u_q[SUM_PG_W-1:0] == $past(sum_u_q[SUM_PG_W-1:0]) + 1'b1);

  // R9
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_map |=> $stable(native_map_o));

  for (genvar k = 0; k < N_LATCH; k++) begin : g_ro_chk
    logic wr_k;
    assign wr_k = wr_en && (off == OFF_SUM_RO0 + OFF_W'(k));

    // R6
    ro_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_i[k] && !ro_q[k][DATA_W-1] && !wr_k)
        |=> ro_q[k][SUM_PG_W-1:0] == $past(sum_u_q[SUM_PG_W-1:0]));

    // R7
    ro_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ro_q[k][DATA_W-1] && !wr_k) |=> $stable(ro_q[k]));
  end
endmodule

bind pg_bus_slave pg_bus_slave_chk #(.DATA_W(DATA_W), .SUM_PG_W(SUM_PG_W), .N_LATCH(N_LATCH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .bcast_rd_o(bcast_rd_o),
  .ind_sel(ind_sel), .bc_sel(bc_sel), .wr_en(wr_en), .off(off),
  .latch_i(latch_i), .sum_u_q(sum_u_q), .ro_q(ro_q), .native_map_o(native_map_o)
);

// File: tb/test_pg_bus_slave.sv
module test_pg_bus_slave;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  board_id;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        wr, rd;
  logic [2:0]  latch;
  logic [7:0]  rdata;
  logic        bus_sel, bcast_rd, native_map;
  logic [5:0]  thr_use, thr_bus;
  logic [2:0]  set_use, set_bus, sum_use, sum_f, sum_s, sum_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_data_q[$];
  logic       exp_flag_q[$];
  logic       exp_sel_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pg_bus_slave i_pg_bus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .board_id_i(board_id), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .bus_sel_o(bus_sel), .bcast_rd_o(bcast_rd), .latch_i(latch),
    .thr_use_pg_o(thr_use), .thr_bus_pg_o(thr_bus),
    .set_use_pg_o(set_use), .set_bus_pg_o(set_bus),
    .sum_use_pg_o(sum_use), .sum_f_pg_o(sum_f), .sum_s_pg_o(sum_s),
    .sum_v_pg_o(sum_v), .native_map_o(native_map)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations for each read cycle
  always @(negedge clk) begin
    if (rd && exp_data_q.size() > 0) begin
      automatic logic [7:0] ed = exp_data_q.pop_front();
      automatic logic       ef = exp_flag_q.pop_front();
      automatic logic       es = exp_sel_q.pop_front();
      automatic string      t  = tag_q.pop_front();
      chk(rdata, ed, {t, " rdata"});
      chk(bcast_rd, ef, {t, " bcast flag"});
      chk(bus_sel, es, {t, " select"});
    end
  end

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d, input logic [2:0] lv = 3'b000);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1; latch = lv;
    @(posedge clk); #1;
    wr = 1'b0; latch = 3'b000;
  endtask

  task automatic pulse_latch(input logic [2:0] lv);
    @(posedge clk); #1;
    latch = lv;
    @(posedge clk); #1;
    latch = 3'b000;
  endtask

  task automatic bus_rd(input logic [12:0] a, input logic [7:0] ed, input logic ef,
                        input logic es, input string t);
    @(posedge clk); #1;
    exp_data_q.push_back(ed); exp_flag_q.push_back(ef);
    exp_sel_q.push_back(es); tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  initial begin
    board_id = 4'h5; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0; latch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(native_map, 0, "R10 map at reset");
    chk({thr_use, thr_bus, set_use, set_bus, sum_use, sum_f, sum_s, sum_v}, 0, "R10 pages at reset");
    rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) bus_rd(13'h05E0 + 13'(k), 8'h00, 1'b0, 1'b1, "R10 page reg reset");
    bus_rd(13'h05FF, 8'h00, 1'b0, 1'b1, "R10 map reg reset");

    // R4, R11 full byte readback
    bus_wr(13'h05E0, 8'hAB);
    bus_wr(13'h05E1, 8'h7F);
    @(negedge clk);
    chk(thr_use, 6'h2B, "R4 thr in-use page");
    chk(thr_bus, 6'h3F, "R4 thr bus page");
    bus_rd(13'h05E0, 8'hAB, 1'b0, 1'b1, "R11 full readback");

    // R1 other card, bad upper bits
    bus_wr(13'h06E2, 8'h55);
    bus_wr(13'h12E0, 8'h11);
    bus_rd(13'h05E2, 8'h00, 1'b0, 1'b1, "R1 foreign write ignored");
    bus_rd(13'h05E0, 8'hAB, 1'b0, 1'b1, "R1 0x12 window ignored");
    bus_rd(13'h06E0, 8'h00, 1'b0, 1'b0, "R1 foreign read");
    board_id = 4'hF;
    bus_wr(13'h0FE2, 8'h07);
    bus_rd(13'h0FE2, 8'h00, 1'b0, 1'b0, "R1 id 0xF never selected");
    board_id = 4'h5;

    // R2, R3, R5 broadcast
    bus_wr(13'h13E3, 8'h0D);
    bus_wr(13'h13E2, 8'h0A);
    @(negedge clk);
    chk(set_bus, 3'd5, "R5 settings bus page");
    chk(set_use, 3'd2, "R2 bcast write settings in-use");
    bus_rd(13'h13E3, 8'h0D, 1'b1, 1'b1, "R3 bcast read");

    // R6 latch and wrap
    bus_wr(13'h05E4, 8'h06);
    pulse_latch(3'b001);
    @(negedge clk);
    chk(sum_f, 3'd6, "R6 fast takes in-use");
    chk(sum_use, 3'd7, "R6 in-use advanced");
    pulse_latch(3'b010);
    @(negedge clk);
    chk(sum_s, 3'd7, "R6 slow takes in-use");
    chk(sum_use, 3'd0, "R6 in-use wraps mod 8");
    chk(sum_f, 3'd6, "R6 fast untouched by slow latch");

    // R7, R8 freeze and simultaneous strobes
    bus_wr(13'h05E4, 8'h03);
    bus_wr(13'h05E7, 8'h85);
    pulse_latch(3'b111);
    @(negedge clk);
    chk(sum_f, 3'd3, "R8 fast shares pre-advance value");
    chk(sum_s, 3'd3, "R8 slow shares pre-advance value");
    chk(sum_use, 3'd4, "R8 single advance");
    chk(sum_v, 3'd5, "R7 frozen very-slow page");
    bus_rd(13'h05E7, 8'h85, 1'b0, 1'b1, "R7 frozen register intact");

    // R12 write beats latch
    bus_wr(13'h05E5, 8'h02, 3'b001);
    @(negedge clk);
    chk(sum_f, 3'd2, "R12 write wins over latch");
    chk(sum_use, 3'd5, "R12 in-use still advances");

    // R9 map flag
    bus_wr(13'h05FF, 8'h80);
    @(negedge clk);
    chk(native_map, 1, "R9 native map set");
    bus_wr(13'h13FF, 8'h7F);
    @(negedge clk);
    chk(native_map, 0, "R9 original map via bcast");

    // R11 unmapped offset
    bus_wr(13'h0510, 8'h99);
    bus_rd(13'h0510, 8'h00, 1'b0, 1'b1, "R11 unmapped offset");

    repeat (3) @(posedge clk);
    chk(exp_data_q.size(), 0, "scoreboard drained");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule